// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block sits on the host side of an asynchronous 8-bit parallel NAND flash bus. It erases one block of flash when user logic gives it a block number and a one-cycle `start_i` pulse. The sequencer first sends the erase-setup opcode `0x60`. It then sends three row-address bytes and the confirm opcode `0xD0`. Next it waits for the flash Ready/Busy line to go back high. Finally it sends the status opcode `0x70`, reads one status byte, and reports pass or fail.

A one-cycle `flash_reset_i` pulse makes the block send the flash reset opcode `0xFF` and wait for Ready/Busy in place of an erase. All strobe timing is counted in clocks of `clk`. If Ready/Busy stays low too long, a timeout counter stops the wait.

The block has thirteen states:
- `ST_IDLE`: waits for a request.
- `ST_SETUP`, `ST_ADDR0`, `ST_ADDR1`, `ST_ADDR2`, `ST_CONFIRM`: one bus write each.
- `ST_GUARD`: waits a fixed time before reading Ready/Busy.
- `ST_POLL`: waits for Ready/Busy to go high.
- `ST_STAT_CMD`: writes the status opcode.
- `ST_STAT_RD`: reads the status byte.
- `ST_RST_CMD`, `ST_RST_GUARD`, `ST_RST_POLL`: the same steps for the reset opcode.

The state transitions are:
- `ST_IDLE` → `ST_RST_CMD` on a reset request. A reset request wins when it arrives in the same cycle as a start.
- `ST_IDLE` → `ST_SETUP` on a start.
- Each bus-write state moves to the next state when its bus cycle completes, in the order `ST_SETUP` → `ST_ADDR0` → `ST_ADDR1` → `ST_ADDR2` → `ST_CONFIRM` → `ST_GUARD`.
- `ST_GUARD` → `ST_POLL` when the guard count expires. `ST_RST_GUARD` → `ST_RST_POLL` in the same way.
- `ST_POLL` → `ST_STAT_CMD` when Ready/Busy is high.
- `ST_POLL` → `ST_IDLE` on a timeout.
- `ST_STAT_CMD` → `ST_STAT_RD` → `ST_IDLE`.
- `ST_RST_CMD` → `ST_RST_GUARD` when its bus cycle completes.
- `ST_RST_POLL` → `ST_IDLE` when Ready/Busy is high or on a timeout.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, the outputs take these values: `nand_ce_n_o`, `nand_we_n_o` and `nand_re_n_o` are high; `nand_cle_o`, `nand_ale_o`, `nand_dq_oe_o`, `busy_o`, `done_o`, `fail_o` and `timeout_o` are low.
- R2: An erase writes exactly five bytes, in this order:
  - `0x60` with CLE high;
  - three bytes with ALE high;
  - `0xD0` with CLE high.
- R3: The address bytes for block number `b` (12 bits) are:
  - byte 0 = `{b[2:0], 5'b00000}`;
  - byte 1 = `b[10:3]`;
  - byte 2 = `{7'b0, b[11]}`.
  DQ bits 7..1 are low in the last address byte.
- R4: Every write strobe holds `nand_we_n_o` low for exactly `WE_LOW_CYC` clocks. CLE, ALE and DQ stay constant through the low phase and the following `WE_HIGH_CYC` high clocks. CLE and ALE are never high together.
- R5: `nand_ce_n_o` is low from the cycle after a request is accepted until the block returns to idle, so it is low on every strobe.
- R6: After the confirm write, the block waits `RB_GUARD_CYC` clocks and then waits for Ready/Busy to go high. Only then does it write `0x70` with CLE high and issue exactly one read strobe.
- R7: At the end of the status read, `done_o` pulses for one cycle. `fail_o` pulses in the same cycle if, and only if, status bit 0 was 1.
- R8: If Ready/Busy is still low after `BUSY_LIMIT_CYC` polling clocks, `timeout_o` pulses for one cycle. No status opcode is sent, and the block returns to idle.
- R9: A `start_i` or `flash_reset_i` pulse while `busy_o` is high has no effect: it writes no extra bytes and does not change the address that is sent.
- R10: A reset request in idle writes `0xFF` with CLE high and then waits for Ready/Busy. It then pulses `done_o` with `fail_o` low and does no status read. A reset request wins over a start that arrives in the same cycle.
- R11: `busy_o` is high from the cycle after a request is accepted until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Erase request pulse |
| blk_addr_i | input | BLK_W | Block number to erase |
| flash_reset_i | input | 1 | Flash reset request pulse |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus, driven out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus, read in |
| nand_rb_i | input | 1 | Ready/Busy from the flash, low while busy |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Sequence completed (one-cycle pulse) |
| fail_o | output | 1 | Erase reported failure (one-cycle pulse) |
| timeout_o | output | 1 | Ready/Busy wait timed out (one-cycle pulse) |

## Verification
The hardest situation to reach from the ports is a start request that lands in the middle of an erase. The request must arrive while Ready/Busy is being held low, so the bench's flash model keeps Ready/Busy low for a chosen number of clocks after it sees `0xD0`. The bench pulses `start_i` with a different block number partway through that busy window. It then compares the full byte log and checks the final byte count after the run has settled. The timeout path uses the same model with a busy time longer than the limit.

// File: rtl/nbe_pkg.sv
package nbe_pkg;
    typedef enum logic [1:0] {
        BUS_CMD,
        BUS_ADDR,
        BUS_READ
    } bus_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADDR0,
        ST_ADDR1,
        ST_ADDR2,
        ST_CONFIRM,
        ST_GUARD,
        ST_POLL,
        ST_STAT_CMD,
        ST_STAT_RD,
        ST_RST_CMD,
        ST_RST_GUARD,
        ST_RST_POLL
    } seq_state_e;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_RESET       = 8'hFF;

    localparam int ROW_CYCLES = 3;
    localparam int ROW_W      = ROW_CYCLES * 8;
endpackage

// File: rtl/nbe_timer.sv
module nbe_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/nbe_bus_cycle.sv
module nbe_bus_cycle
    import nbe_pkg::*;
#(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  bus_kind_e  kind_i,
    input  logic [7:0] wdata_i,
    output logic       done_o,
    output logic       sample_o,
    output logic       cle_o,
    output logic       ale_o,
    output logic       we_n_o,
    output logic       re_n_o,
    output logic [7:0] dq_o,
    output logic       dq_oe_o
);
    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} phase_e;

    phase_e        phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    bus_kind_e     kind_q;
    logic [7:0]    data_q;
    logic          low_last, high_last;

    assign low_last  = (phase_q == P_LOW)  && (cnt_q == CW'(LOW_CYC - 1));
    assign high_last = (phase_q == P_HIGH) && (cnt_q == CW'(HIGH_CYC - 1));

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (phase_q)
            P_IDLE: begin
                cnt_d = '0;
                if (req_i) phase_d = P_LOW;
            end
            P_LOW: begin
                if (low_last) begin
                    phase_d = P_HIGH;
                    cnt_d   = '0;
                end
            end
            P_HIGH: begin
                if (high_last) begin
                    phase_d = P_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                phase_d = P_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= P_IDLE;
            cnt_q   <= '0;
            kind_q  <= BUS_CMD;
            data_q  <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            if (phase_q == P_IDLE && req_i) begin
                kind_q <= kind_i;
                data_q <= wdata_i;
            end
        end
    end

    always_comb begin
        done_o   = high_last;
        sample_o = low_last && (kind_q == BUS_READ);
        cle_o    = (phase_q != P_IDLE) && (kind_q == BUS_CMD);
        ale_o    = (phase_q != P_IDLE) && (kind_q == BUS_ADDR);
        we_n_o   = !((phase_q == P_LOW) && (kind_q != BUS_READ));
        re_n_o   = !((phase_q == P_LOW) && (kind_q == BUS_READ));
        dq_oe_o  = (phase_q != P_IDLE) && (kind_q != BUS_READ);
        dq_o     = dq_oe_o ? data_q : 8'h00;
    end

    // R4
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));

    // R4
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == P_HIGH) |-> ($stable(dq_o) && $stable(cle_o) && $stable(ale_o)));
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nbe_pkg::*;
#(
    parameter int BLK_W          = 12,
    parameter int IGN_BITS       = 5,
    parameter int WE_LOW_CYC     = 2,
    parameter int WE_HIGH_CYC    = 2,
    parameter int RB_GUARD_CYC   = 4,
    parameter int BUSY_LIMIT_CYC = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] blk_addr_i,
    input  logic             flash_reset_i,
    output logic             nand_ce_n_o,
    output logic             nand_cle_o,
    output logic             nand_ale_o,
    output logic             nand_we_n_o,
    output logic             nand_re_n_o,
    output logic [7:0]       nand_dq_o,
    output logic             nand_dq_oe_o,
    input  logic [7:0]       nand_dq_i,
    input  logic             nand_rb_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic             timeout_o
);
    localparam int PAD_W = ROW_W - BLK_W - IGN_BITS;

    seq_state_e       state_q, state_d;
    logic [BLK_W-1:0] blk_q;
    logic [ROW_W-1:0] row_vec;
    logic [1:0]       rb_sync_q;
    logic             rb_s;
    logic             stat_bit_q;
    logic             done_q, fail_q, tout_q;

    logic       bus_req, bus_done, bus_sample;
    bus_kind_e  bus_kind;
    logic [7:0] bus_wdata;
    logic       guard_run, guard_exp, wait_run, wait_exp;

    assign row_vec = {{PAD_W{1'b0}}, blk_q, {IGN_BITS{1'b0}}};
    assign rb_s    = rb_sync_q[1];

    nbe_bus_cycle #(
        .LOW_CYC  (WE_LOW_CYC),
        .HIGH_CYC (WE_HIGH_CYC)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (bus_req),
        .kind_i   (bus_kind),
        .wdata_i  (bus_wdata),
        .done_o   (bus_done),
        .sample_o (bus_sample),
        .cle_o    (nand_cle_o),
        .ale_o    (nand_ale_o),
        .we_n_o   (nand_we_n_o),
        .re_n_o   (nand_re_n_o),
        .dq_o     (nand_dq_o),
        .dq_oe_o  (nand_dq_oe_o)
    );

    assign guard_run = (state_q == ST_GUARD) || (state_q == ST_RST_GUARD);
    assign wait_run  = (state_q == ST_POLL)  || (state_q == ST_RST_POLL);

    nbe_timer #(.LIMIT(RB_GUARD_CYC)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (guard_run),
        .expired_o (guard_exp)
    );

    nbe_timer #(.LIMIT(BUSY_LIMIT_CYC)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (wait_run),
        .expired_o (wait_exp)
    );

    // Bus request selection per state
    always_comb begin
        bus_req   = 1'b0;
        bus_kind  = BUS_CMD;
        bus_wdata = 8'h00;
        unique case (state_q)
            ST_SETUP:    begin bus_req = 1'b1; bus_wdata = OP_ERASE_SETUP; end
            ST_ADDR0:    begin bus_req = 1'b1; bus_kind = BUS_ADDR; bus_wdata = row_vec[7:0];   end
            ST_ADDR1:    begin bus_req = 1'b1; bus_kind = BUS_ADDR; bus_wdata = row_vec[15:8];  end
            ST_ADDR2:    begin bus_req = 1'b1; bus_kind = BUS_ADDR; bus_wdata = row_vec[23:16]; end
            ST_CONFIRM:  begin bus_req = 1'b1; bus_wdata = OP_ERASE_GO; end
            ST_STAT_CMD: begin bus_req = 1'b1; bus_wdata = OP_STATUS; end
            ST_STAT_RD:  begin bus_req = 1'b1; bus_kind = BUS_READ; end
            ST_RST_CMD:  begin bus_req = 1'b1; bus_wdata = OP_RESET; end
            default:     bus_req = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flash_reset_i)  state_d = ST_RST_CMD;
                else if (start_i)   state_d = ST_SETUP;
            end
            ST_SETUP:     if (bus_done)  state_d = ST_ADDR0;
            ST_ADDR0:     if (bus_done)  state_d = ST_ADDR1;
            ST_ADDR1:     if (bus_done)  state_d = ST_ADDR2;
            ST_ADDR2:     if (bus_done)  state_d = ST_CONFIRM;
            ST_CONFIRM:   if (bus_done)  state_d = ST_GUARD;
            ST_GUARD:     if (guard_exp) state_d = ST_POLL;
            ST_POLL: begin
                if (rb_s)          state_d = ST_STAT_CMD;
                else if (wait_exp) state_d = ST_IDLE;
            end
            ST_STAT_CMD:  if (bus_done)  state_d = ST_STAT_RD;
            ST_STAT_RD:   if (bus_done)  state_d = ST_IDLE;
            ST_RST_CMD:   if (bus_done)  state_d = ST_RST_GUARD;
            ST_RST_GUARD: if (guard_exp) state_d = ST_RST_POLL;
            ST_RST_POLL: begin
                if (rb_s || wait_exp) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            blk_q     <= '0;
            rb_sync_q <= 2'b11;
        end else begin
            state_q   <= state_d;
            rb_sync_q <= {rb_sync_q[0], nand_rb_i};
            if (state_q == ST_IDLE && start_i && !flash_reset_i) begin
                blk_q <= blk_addr_i;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_bit_q <= 1'b0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
            tout_q     <= 1'b0;
        end else begin
            if (bus_sample) stat_bit_q <= nand_dq_i[0];
            done_q <= ((state_q == ST_STAT_RD) && bus_done)
                   || ((state_q == ST_RST_POLL) && rb_s);
            fail_q <= (state_q == ST_STAT_RD) && bus_done && stat_bit_q;
            tout_q <= wait_run && !rb_s && wait_exp;
        end
    end

    assign nand_ce_n_o = (state_q == ST_IDLE);
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign fail_o      = fail_q;
    assign timeout_o   = tout_q;

    // R5
    ce_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n_o || !nand_re_n_o) |-> !nand_ce_n_o);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    // R8
    timeout_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!busy_o && !done_o));

    // R9
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(blk_q));

    // R3
    last_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ADDR2) && nand_ale_o) |-> (nand_dq_o[7:1] == 7'd0));
endmodule

// File: tb/nand_erase_seq_tb.sv
module nand_erase_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WE_LO      = 2;
    localparam int WE_HI      = 2;
    localparam int GUARD      = 4;
    localparam int LIMIT      = 300;
    localparam int NVEC       = 6;
    // {block[11:0], status[7:0], busy clocks[15:0]}
    localparam logic [35:0] VECS [NVEC] = '{
        {12'h000, 8'hE0, 16'd20},
        {12'hFFF, 8'hE1, 16'd40},
        {12'h801, 8'hC0, 16'd5},
        {12'h3A5, 8'h01, 16'd120},
        {12'h555, 8'hFE, 16'd1},
        {12'h2AA, 8'h41, 16'd250}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] blk = '0;
    logic        frst = 1'b0;
    logic        ce_n, cle, ale, we_n, re_n, dq_oe, rb;
    logic [7:0]  dq_o, dq_i;
    logic        busy, done, fail, tout;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [7:0]  cur_stat = 8'h00;
    int          cur_busy = 0;
    logic [9:0]  log_q [256];
    int          log_n = 0;
    int          rd_n = 0;
    int          width_err = 0;
    int          ce_err = 0;
    int          busy_cnt = 0;
    logic        we_prev = 1'b1;
    logic        re_prev = 1'b1;
    int          low_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rb   = (busy_cnt == 0);
    assign dq_i = !re_n ? cur_stat : 8'h00;

    nand_erase_seq #(
        .BLK_W          (12),
        .IGN_BITS       (5),
        .WE_LOW_CYC     (WE_LO),
        .WE_HIGH_CYC    (WE_HI),
        .RB_GUARD_CYC   (GUARD),
        .BUSY_LIMIT_CYC (LIMIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_addr_i(blk),
        .flash_reset_i(frst), .nand_ce_n_o(ce_n), .nand_cle_o(cle),
        .nand_ale_o(ale), .nand_we_n_o(we_n), .nand_re_n_o(re_n),
        .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_i),
        .nand_rb_i(rb), .busy_o(busy), .done_o(done), .fail_o(fail),
        .timeout_o(tout)
    );

    // Flash model, sampled away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        if (!we_n) low_cnt = low_cnt + 1;
        if (we_n && !we_prev) begin
            log_q[log_n[7:0]] = {cle, ale, dq_o};
            log_n = log_n + 1;
            if (low_cnt != WE_LO) width_err = width_err + 1;
            if (ce_n) ce_err = ce_err + 1;
            if (cle && (dq_o == 8'hD0 || dq_o == 8'hFF)) busy_cnt = cur_busy;
            low_cnt = 0;
        end
        if (!re_n && re_prev) begin
            rd_n = rd_n + 1;
            if (ce_n) ce_err = ce_err + 1;
        end
        we_prev = we_n;
        re_prev = re_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_byte(input logic [11:0] b, input int k);
        logic [23:0] row;
        row = {7'd0, b, 5'd0};
        return row[8*k +: 8];
    endfunction

    task automatic wait_end(output bit got_done, output bit got_fail, output bit got_tout);
        got_done = 0; got_fail = 0; got_tout = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done || tout) begin
                got_done = done; got_fail = fail; got_tout = tout;
                break;
            end
        end
    endtask

    task automatic check_log(input int base, input logic [11:0] b, input string req);
        logic [9:0] exp [5];
        exp[0] = {2'b10, 8'h60};
        exp[1] = {2'b01, addr_byte(b, 0)};
        exp[2] = {2'b01, addr_byte(b, 1)};
        exp[3] = {2'b01, addr_byte(b, 2)};
        exp[4] = {2'b10, 8'hD0};
        for (int k = 0; k < 5; k++) begin
            chk(log_q[(base + k) % 256] == exp[k], req, $sformatf("write %0d", k),
                int'(log_q[(base + k) % 256]), int'(exp[k]));
        end
    endtask

    task automatic run_erase(input logic [11:0] b, input logic [7:0] st, input int bc);
        int base, rbase, werr, cerr;
        bit gd, gf, gt;
        cur_stat = st; cur_busy = bc;
        base = log_n; rbase = rd_n; werr = width_err; cerr = ce_err;
        @(negedge clk); start = 1'b1; blk = b;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R11", "busy after accept", int'(busy), 1);
        wait_end(gd, gf, gt);
        chk(gd && !gt, "R6", "erase finished", int'(gd), 1);
        chk(gf == st[0], "R7", "fail flag", int'(gf), int'(st[0]));
        @(negedge clk);
        chk(!done && !fail, "R7", "pulse width", int'(done), 0);
        // R2 R3: the writes in order
        chk(log_n - base == 6, "R2", "write count", log_n - base, 6);
        check_log(base, b, "R3");
        chk(log_q[(base + 5) % 256] == {2'b10, 8'h70}, "R6", "status opcode",
            int'(log_q[(base + 5) % 256]), 'h270);
        chk(rd_n - rbase == 1, "R6", "read strobes", rd_n - rbase, 1);
        chk(width_err == werr, "R4", "we low width errors", width_err - werr, 0);
        chk(ce_err == cerr, "R5", "strobe with ce high", ce_err - cerr, 0);
        chk(!busy && ce_n, "R11", "idle after erase", int'(busy), 0);
    endtask

    initial begin
        bit gd, gf, gt;
        int base, rbase;
        repeat (3) @(negedge clk);
        // R1: state while and just after reset
        chk(ce_n && we_n && re_n, "R1", "strobes high", {ce_n, we_n, re_n}, 7);
        chk(!cle && !ale && !dq_oe, "R1", "latches low", {cle, ale, dq_oe}, 0);
        chk(!busy && !done && !fail && !tout, "R1", "flags low", {busy, done, fail, tout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && ce_n, "R1", "idle after release", int'(busy), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_erase(VECS[v][35:24], VECS[v][23:16], int'(VECS[v][15:0]));
            repeat (3) @(negedge clk);
        end

        // R8: busy longer than the limit
        cur_busy = 800; base = log_n; rbase = rd_n;
        @(negedge clk); start = 1'b1; blk = 12'h123;
        @(negedge clk); start = 1'b0;
        wait_end(gd, gf, gt);
        chk(gt && !gd, "R8", "timeout pulse", int'(gt), 1);
        @(negedge clk);
        chk(!tout && !busy, "R8", "single pulse and idle", {tout, busy}, 0);
        chk(log_n - base == 5, "R8", "no status opcode", log_n - base, 5);
        chk(rd_n == rbase, "R8", "no read strobe", rd_n - rbase, 0);
        while (busy_cnt != 0) @(negedge clk);

        // R9: requests during an erase are ignored
        cur_busy = 60; cur_stat = 8'h00; base = log_n;
        @(negedge clk); start = 1'b1; blk = 12'h0F0;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1; frst = 1'b1; blk = 12'hA0F;
        @(negedge clk); start = 1'b0; frst = 1'b0;
        wait_end(gd, gf, gt);
        chk(gd && !gf, "R9", "first erase completes", int'(gd), 1);
        check_log(base, 12'h0F0, "R9");
        repeat (30) @(negedge clk);
        chk(log_n - base == 6, "R9", "no extra writes", log_n - base, 6);
        chk(!busy, "R9", "stays idle", int'(busy), 0);

        // R10: reset request beats a simultaneous start
        cur_busy = 15; cur_stat = 8'hFF; base = log_n; rbase = rd_n;
        @(negedge clk); start = 1'b1; frst = 1'b1; blk = 12'h777;
        @(negedge clk); start = 1'b0; frst = 1'b0;
        wait_end(gd, gf, gt);
        chk(gd && !gf && !gt, "R10", "reset done no fail", {gd, gf, gt}, 4);
        chk(log_n - base == 1, "R10", "one write", log_n - base, 1);
        chk(log_q[base % 256] == {2'b10, 8'hFF}, "R10", "reset opcode",
            int'(log_q[base % 256]), 'h2FF);
        chk(rd_n == rbase, "R10", "no status read", rd_n - rbase, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule